// File: doc/BRIEF.md
# Serial Transmitter with Automatic Handshake Release

This block turns bytes into asynchronous serial frames on a single output line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period can be set in sixteenth-of-a-bit steps. Characters enter through a valid/ready write port and wait in an eight-entry queue ahead of the shift register. All bit timing comes from an external single-cycle tick at sixteen times the baud rate.

A request-to-send style handshake output is set and cleared by command. When the automatic release mode is on and the transmitter has been disabled, the block drops the handshake output by itself. This happens one full bit time after the last stop period of the last queued character ends. Software can therefore disable the transmitter straight after its final write and leave the line turnaround to the hardware.

Write port rules: a byte moves when `wr_valid` and `wr_ready` are both high on a rising clock edge. `wr_ready` is low while the transmitter is disabled or the queue is full. A byte offered while `wr_ready` is low is not taken, and the sender must hold it until `wr_ready` rises.

Top module: `sertx_autorts`

## Requirements
- R1: After reset, `txd` is 1, `rts` is 0, `wr_ready` is 0 (transmitter disabled), mode is 0 and stop extension is 0.
- R2: A frame is a 0 start bit, then N data bits LSB first, where N = 5 + mode[1:0], then a stop period at 1. `txd` is 1 whenever no frame is in progress.
- R3: Parity uses mode[3:2]. Code 0 sends no parity bit. Code 1 is even, so that data plus parity has an even number of ones. Code 2 is odd. Code 3 sends the fixed level mode[4]. The parity bit follows the last data bit.
- R4: The start, data and parity bits last 16 ticks each. The stop period lasts 16 + min(S, 16) ticks, where S is the 5-bit stop extension. A queued character starts in the cycle its predecessor's stop period ends. `txd` changes only when a tick is consumed, except when a frame starts from idle.
- R5: Up to 8 characters wait behind the character being shifted. `wr_ready` is 0 while the queue is full, nothing is overwritten, and characters go out in write order.
- R6: `wr_ready` is 0 while the transmitter is disabled. A byte offered then has no effect, and nothing is sent for it even after the transmitter is enabled again.
- R7: Disabling the transmitter does not cut off the character being shifted or any character still queued.
- R8: With mode[5] = 1 and the transmitter disabled, `rts` falls to 0 exactly 16 ticks after the stop period of the last character ends.
- R9: `rts` is never released automatically while the transmitter is enabled or mode[5] = 0.
- R10: A pulse on `cmd_valid` applies `cmd_op`: 0 enables the transmitter, 1 disables it, 2 sets `rts` to 1, and 3 clears `rts` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | Single-cycle tick at 16x the bit rate |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Byte can be accepted |
| wr_data | input | 8 | Character to send; only the low N bits are used |
| mode_we | input | 1 | Load the mode register |
| mode_wdata | input | 6 | Length [1:0], parity [3:2], fixed level [4], auto release [5] |
| stop_we | input | 1 | Load the stop extension |
| stop_wdata | input | 5 | Extra stop ticks beyond one bit, saturating at 16 |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| txd | output | 1 | Serial data output |
| rts | output | 1 | Handshake output, 1 = requesting |

## Verification
The assertions check on every cycle that the queue never grows past its depth and never grows while the transmitter is disabled. They also check that the line holds still between ticks and idles high. Every fall of `rts` must trace back to a clear command or to the release condition, and every rise must trace back to a set command.

Only the bench scenarios can show the rest. These are the bit order and parity of each format, the exact stop length measured between back-to-back frames, and the order of characters through a full queue. They also include the drain after an early disable and the release falling exactly one bit time after the line goes quiet.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W        = 8;
  localparam int MIN_BITS      = 5;
  localparam int TICKS_PER_BIT = 16;
  localparam int STOP_EXT_MAX  = 16;

  typedef enum logic [2:0] {
    SH_IDLE, SH_START, SH_DATA, SH_PAR, SH_STOP
  } sh_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FIXED = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    CMD_TX_ON   = 2'd0,
    CMD_TX_OFF  = 2'd1,
    CMD_RTS_SET = 2'd2,
    CMD_RTS_CLR = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [1:0] len_code;
    par_mode_e  par_mode;
    logic       par_level;
    logic [4:0] stop_extra;
  } frame_cfg_t;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    fill
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int TPB = TICKS_PER_BIT,
  localparam int TW = $clog2(2 * TPB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  sh_state_e         state;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [TW-1:0]     tcnt;
  logic [TW-1:0]     stop_len_q;
  logic [3:0]        bidx;
  logic              par_q;
  logic [3:0]        nbits_q;
  logic              end_now;
  logic [DATA_W-1:0] mask;
  logic              par_calc;

  assign nbits_q = 4'(MIN_BITS) + {2'b00, cfg_q.len_code};
  assign busy    = (state != SH_IDLE);
  assign end_now = (state == SH_STOP) ? (tcnt == stop_len_q - 1'b1)
                                      : (tcnt == TW'(TPB - 1));
  assign pop     = avail && ((state == SH_IDLE) ||
                             (state == SH_STOP && tick && end_now));

  assign mask = {DATA_W{1'b1}} >> (2'd3 - cfg.len_code);

  always_comb begin
    unique case (cfg.par_mode)
      PAR_EVEN:  par_calc = ^(din & mask);
      PAR_ODD:   par_calc = ~^(din & mask);
      PAR_FIXED: par_calc = cfg.par_level;
      default:   par_calc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SH_IDLE;
      txd        <= 1'b1;
      tcnt       <= '0;
      bidx       <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      cfg_q      <= '0;
      stop_len_q <= TW'(TPB);
    end else if (pop) begin
      shreg      <= din;
      cfg_q      <= cfg;
      par_q      <= par_calc;
      stop_len_q <= TW'(TPB) + TW'(cfg.stop_extra);
      tcnt       <= '0;
      bidx       <= '0;
      state      <= SH_START;
      txd        <= 1'b0;
    end else if (tick && busy) begin
      if (!end_now) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (state)
          SH_START: begin
            state <= SH_DATA;
            txd   <= shreg[0];
          end
          SH_DATA: begin
            if (bidx == nbits_q - 1'b1) begin
              if (cfg_q.par_mode != PAR_NONE) begin
                state <= SH_PAR;
                txd   <= par_q;
              end else begin
                state <= SH_STOP;
                txd   <= 1'b1;
              end
            end else begin
              bidx  <= bidx + 1'b1;
              shreg <= shreg >> 1;
              txd   <= shreg[1];
            end
          end
          SH_PAR: begin
            state <= SH_STOP;
            txd   <= 1'b1;
          end
          default: begin
            state <= SH_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sertx_handshake.sv
module sertx_handshake #(
  parameter int TPB = 16,
  localparam int CW = $clog2(TPB)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic set_req,
  input  logic clr_req,
  input  logic auto_en,
  input  logic tx_en,
  input  logic drained,
  output logic rts
);
  logic          armed;
  logic [CW-1:0] cnt;
  logic          release_now;

  assign armed       = auto_en && !tx_en && drained;
  assign release_now = armed && tick && (cnt == CW'(TPB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!armed) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == CW'(TPB - 1)) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rts <= 1'b0;
    else if (clr_req)     rts <= 1'b0;
    else if (set_req)     rts <= 1'b1;
    else if (release_now) rts <= 1'b0;
  end
endmodule

// File: rtl/sertx_autorts.sv
module sertx_autorts
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_we,
  input  logic [5:0]        mode_wdata,
  input  logic              stop_we,
  input  logic [4:0]        stop_wdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              txd,
  output logic              rts
);
  logic [5:0]        mode_q;
  logic [4:0]        stop_q;
  logic              tx_en;
  logic              auto_en;
  logic [CNT_W-1:0]  fill;
  logic              q_empty, q_full;
  logic              push, pop;
  logic [DATA_W-1:0] q_data;
  logic              sh_busy;
  frame_cfg_t        cfg;

  assign q_empty  = (fill == '0);
  assign q_full   = (fill == CNT_W'(FIFO_DEPTH));
  assign wr_ready = tx_en && !q_full;
  assign push     = wr_valid && wr_ready;
  assign auto_en  = mode_q[5];

  always_comb begin
    cfg.len_code   = mode_q[1:0];
    cfg.par_mode   = par_mode_e'(mode_q[3:2]);
    cfg.par_level  = mode_q[4];
    cfg.stop_extra = (stop_q > 5'(STOP_EXT_MAX)) ? 5'(STOP_EXT_MAX) : stop_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      stop_q <= '0;
      tx_en  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (stop_we) stop_q <= stop_wdata;
      if (cmd_valid && cmd_op == CMD_TX_ON)  tx_en <= 1'b1;
      if (cmd_valid && cmd_op == CMD_TX_OFF) tx_en <= 1'b0;
    end
  end

  sertx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data),
    .pop(pop), .dout(q_data), .fill(fill)
  );

  sertx_shifter #(.TPB(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .cfg(cfg),
    .avail(!q_empty), .din(q_data), .pop(pop), .txd(txd), .busy(sh_busy)
  );

  sertx_handshake #(.TPB(TICKS_PER_BIT)) u_hs (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x),
    .set_req(cmd_valid && cmd_op == CMD_RTS_SET),
    .clr_req(cmd_valid && cmd_op == CMD_RTS_CLR),
    .auto_en(auto_en), .tx_en(tx_en), .drained(q_empty && !sh_busy),
    .rts(rts)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
  import sertx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_16x,
  input logic          txd,
  input logic          rts,
  input logic          tx_en,
  input logic          auto_en,
  input logic          sh_busy,
  input logic [CW-1:0] fill,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op
);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) |=> (fill <= CW'(DEPTH)));

  assert_no_growth_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (fill <= $past(fill)));

  assert_line_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sh_busy) && !$past(tick_16x)) |-> $stable(txd));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> txd);

  assert_release_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> (($past(cmd_valid) && $past(cmd_op) == CMD_RTS_CLR) ||
                    ($past(auto_en) && !$past(tx_en) && !$past(sh_busy) &&
                     $past(fill) == '0)));

  assert_set_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> ($past(cmd_valid) && $past(cmd_op) == CMD_RTS_SET));
endmodule

bind sertx_autorts sertx_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .txd(txd), .rts(rts),
  .tx_en(tx_en), .auto_en(auto_en), .sh_busy(sh_busy), .fill(fill),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/tb_sertx_autorts.sv
module tb_sertx_autorts;
  localparam int CLK_P = 10;
  localparam int TDIV  = 2;
  localparam int NVEC  = 6;
  // {mode[5:0], stop[4:0], data[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {6'h03, 5'd0,  8'h5A},
    {6'h07, 5'd8,  8'hC3},
    {6'h09, 5'd16, 8'h1F},
    {6'h0C, 5'd3,  8'h15},
    {6'h1E, 5'd20, 8'h6B},
    {6'h06, 5'd1,  8'hFF}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic wr_valid = 0, mode_we = 0, stop_we = 0, cmd_valid = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] mode_wdata = 0;
  logic [4:0] stop_wdata = 0;
  logic [1:0] cmd_op = 0;
  logic wr_ready, txd, rts;
  int checks = 0, fails = 0, tcount = 0, dv = 0;
  bit done = 0;

  sertx_autorts dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .stop_we(stop_we), .stop_wdata(stop_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .txd(txd), .rts(rts)
  );

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk) begin
    dv     <= (dv == TDIV - 1) ? 0 : dv + 1;
    tick   <= rst_n && (dv == TDIV - 1);
    tcount <= tcount + (tick ? 1 : 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_set(input logic [5:0] m, input logic [4:0] s);
    mode_we = 1; mode_wdata = m; stop_we = 1; stop_wdata = s;
    @(negedge clk);
    mode_we = 0; stop_we = 0;
  endtask

  task automatic cmd(input logic [1:0] op);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_t(input int target);
    while (tcount < target) @(negedge clk);
  endtask

  task automatic recv(input int nb, input int hp, input int stopt,
                      output logic [9:0] got, output logic stopv, output int t0);
    got = '0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = tcount;
    for (int i = 0; i < nb + hp; i++) begin
      wait_t(t0 + 16 * (i + 1) + 8);
      got[i] = txd;
    end
    wait_t(t0 + 16 * (1 + nb + hp) + stopt / 2);
    stopv = txd;
  endtask

  function automatic logic [9:0] exp_bits(input logic [7:0] d, input logic [5:0] m);
    int nb = 5 + int'(m[1:0]);
    logic [7:0] mk = 8'hFF >> (3 - int'(m[1:0]));
    logic x = ^(d & mk);
    logic [9:0] e = '0;
    for (int i = 0; i < nb; i++) e[i] = d[i];
    case (m[3:2])
      2'd1: e[nb] = x;
      2'd2: e[nb] = ~x;
      2'd3: e[nb] = m[4];
      default: ;
    endcase
    return e;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] ga, gb;
    logic sa, sb;
    int ta, tb, nb, hp, st, f;
    bit quiet;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(rts === 1'b0, "R1 rts", int'(rts), 0);
    chk(wr_ready === 1'b0, "R1 wr_ready", int'(wr_ready), 0);
    cmd(2'd0);
    chk(wr_ready === 1'b1, "R10 enable", int'(wr_ready), 1);
    cmd(2'd2);
    chk(rts === 1'b1, "R10 rts set", int'(rts), 1);

    // R2 R3 R4: format table
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] m = VEC[v][18:13];
      logic [4:0] s = VEC[v][12:8];
      logic [7:0] d = VEC[v][7:0];
      nb = 5 + int'(m[1:0]);
      hp = (m[3:2] != 0) ? 1 : 0;
      st = 16 + ((s > 16) ? 16 : int'(s));
      cfg_set(m, s);
      fork
        begin wr(d); wr(d ^ 8'hA5); end
        begin recv(nb, hp, st, ga, sa, ta); recv(nb, hp, st, gb, sb, tb); end
      join
      chk(ga == exp_bits(d, m), hp ? "R3 frame a" : "R2 frame a", int'(ga), int'(exp_bits(d, m)));
      chk(gb == exp_bits(d ^ 8'hA5, m), hp ? "R3 frame b" : "R2 frame b", int'(gb), int'(exp_bits(d ^ 8'hA5, m)));
      chk(sa === 1'b1 && sb === 1'b1, "R2 stop level", int'(sa & sb), 1);
      chk(tb - ta == 16 * (1 + nb + hp) + st, "R4 frame spacing", tb - ta, 16 * (1 + nb + hp) + st);
    end

    // R5: queue depth and order
    cfg_set(6'h03, 5'd0);
    fork
      begin
        for (int k = 0; k < 9; k++) wr(8'h30 + 8'(k));
        chk(wr_ready === 1'b0, "R5 full", int'(wr_ready), 0);
        wr_valid = 1; wr_data = 8'hEE;
        repeat (10) @(negedge clk);
        wr_valid = 0;
      end
      begin
        for (int k = 0; k < 9; k++) begin
          recv(8, 0, 16, ga, sa, ta);
          chk(ga[7:0] == 8'h30 + 8'(k), "R5 order", int'(ga[7:0]), 'h30 + k);
        end
      end
    join
    wait_t(ta + 160 + 40);
    chk(txd === 1'b1, "R5 rejected byte not sent", int'(txd), 1);

    // R9: auto on but enabled
    cfg_set(6'h23, 5'd0);
    fork wr(8'h81); recv(8, 0, 16, ga, sa, ta); join
    wait_t(ta + 160 + 40);
    chk(rts === 1'b1, "R9 enabled keeps rts", int'(rts), 1);

    // R7 R8: disable right after last write
    fork
      begin wr(8'h01); wr(8'h02); wr(8'h03); cmd(2'd1);
        chk(wr_ready === 1'b0, "R6 ready low when off", int'(wr_ready), 0); end
      begin
        for (int k = 1; k <= 3; k++) begin
          recv(8, 0, 16, ga, sa, ta);
          chk(ga[7:0] == 8'(k), "R7 drained char", int'(ga[7:0]), k);
        end
      end
    join
    wait_t(ta + 160 + 12);
    chk(rts === 1'b1, "R8 rts held before bit time", int'(rts), 1);
    wait_t(ta + 160 + 20);
    chk(rts === 1'b0, "R8 rts released", int'(rts), 0);

    // R9: auto off, disabled
    cmd(2'd0); cmd(2'd2); cfg_set(6'h03, 5'd0);
    fork
      begin wr(8'h44); cmd(2'd1); end
      recv(8, 0, 16, ga, sa, ta);
    join
    chk(ga[7:0] == 8'h44, "R7 single char", int'(ga[7:0]), 'h44);
    wait_t(ta + 160 + 40);
    chk(rts === 1'b1, "R9 auto off keeps rts", int'(rts), 1);
    cmd(2'd3);
    chk(rts === 1'b0, "R10 rts clear", int'(rts), 0);

    // R6: writes while disabled ignored
    quiet = 1;
    wr_valid = 1; wr_data = 8'h77;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (wr_ready !== 1'b0) quiet = 0;
    end
    wr_valid = 0;
    chk(quiet, "R6 ready stays low", int'(quiet), 1);
    quiet = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    cmd(2'd0);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    chk(quiet, "R6 offered byte not sent", int'(quiet), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule